// File: doc/BRIEF.md
# Interrupt Select and Trap Entry

This block decides, once per clock, whether a hart takes a trap and where it goes. It qualifies pending interrupts against their enables, ranks them in two tiers (interrupts kept at machine level before those handed down to supervisor level), merges the result with a synchronous exception request, picks the destination privilege from the delegation masks, and computes the handler address, the cause word and the new status fields. It owns the privilege level, the interrupt-enable and previous-enable bits, the previous-privilege fields, both saved exception PCs and both trap vector registers.

While the hart is halted for debugging, interrupts are masked and exceptions are redirected to a per-hart debug ROM entry (breakpoints) or to a shared debug exception address (everything else), with no architectural state touched. A context-load port lets the surrounding pipeline restore privilege and enable bits after a trap return. All results are registered: a request presented before a rising edge shows up at the outputs just after that edge, and the trap strobe lasts one cycle.

Top module: `trap_entry_unit`

## Requirements
- R1: An interrupt line is a candidate only when both its pending bit and its enable bit are 1; a pending bit with a clear enable, or an enable without a pending bit, causes no trap.
- R2: Interrupts whose delegation bit is 0 qualify when the privilege is below machine (encoding 3), or when it is machine and the machine enable bit `mie` is 1.
- R3: Interrupts whose delegation bit is 1 are looked at only when no non-delegated interrupt qualifies; they qualify when the privilege is user (0), or supervisor (1) with `sie` set, and never at machine level.
- R4: Among qualifying interrupts the lowest index wins; the cause word for an interrupt is that index with bit XLEN-1 set, and for an exception it is the exception code with bit XLEN-1 clear.
- R5: A trap is sent to supervisor level (`trap_to_s`=1, privilege becomes 1) only when the current privilege is 0 or 1 and the delegation bit of the trap (interrupt mask bit for interrupts, exception mask bit indexed by the code for exceptions) is 1; otherwise it goes to machine level.
- R6: A machine trap jumps to the machine vector with bit 0 cleared, plus 4 times the interrupt index when vector bit 0 is 1 and the trap is an interrupt; a supervisor trap jumps to the supervisor vector with its two low bits cleared.
- R7: A write to the machine vector stores the data with bit 1 forced to 0 and every other bit, bit 0 included, kept as written.
- R8: On a machine trap, `mpie` takes the old `mie`, `mpp` the old privilege, `mie` clears and `mepc` takes `pc_cur`; on a supervisor trap, `spie` takes the old `sie`, `spp` is 1 when the old privilege was supervisor, `sie` clears and `sepc` takes `pc_cur`.
- R9: With `dbg_active` high, interrupts are ignored; an exception with code 3 (breakpoint) jumps to the debug base plus 4 times `hart_id`, any other code jumps to the debug exception address, `dbg_redirect` is set, and privilege, enables and saved PCs are left unchanged.
- R10: An interrupt is taken only when `at_boundary` is 1; when an interrupt and an exception are both eligible in the same cycle, the interrupt is taken.
- R11: After reset the privilege is machine (3), all enable, previous-enable and previous-privilege fields, both saved PCs, the cause and the trap strobe are 0; a context load sets privilege, `mie` and `sie` at the next edge and is ignored in a cycle that takes a trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pend | input | NIRQ | Pending interrupt lines |
| irq_en | input | NIRQ | Interrupt enable mask |
| irq_dlg | input | NIRQ | Interrupt delegation mask |
| exc_dlg | input | 2**EXC_W | Exception delegation mask, indexed by code |
| at_boundary | input | 1 | Current instruction is at a boundary |
| exc_req | input | 1 | Synchronous exception request |
| exc_code | input | EXC_W | Exception code |
| pc_cur | input | XLEN | PC to save on trap entry |
| dbg_active | input | 1 | Hart is in debug mode |
| hart_id | input | HART_W | Hart index for debug ROM entry |
| vec_wr_m | input | 1 | Write machine trap vector |
| vec_wr_s | input | 1 | Write supervisor trap vector |
| vec_wdata | input | XLEN | Vector write data |
| ld_en | input | 1 | Context load strobe |
| ld_priv | input | 2 | Privilege to load |
| ld_mie | input | 1 | Machine enable to load |
| ld_sie | input | 1 | Supervisor enable to load |
| trap_valid | output | 1 | A trap or debug redirect was taken |
| trap_to_s | output | 1 | Trap went to supervisor level |
| dbg_redirect | output | 1 | Trap was a debug-mode redirect |
| trap_pc | output | XLEN | Next PC of the last trap |
| trap_cause | output | XLEN | Cause word of the last trap |
| priv | output | 2 | Current privilege |
| mie | output | 1 | Machine interrupt enable |
| sie | output | 1 | Supervisor interrupt enable |
| mpie | output | 1 | Machine previous enable |
| spie | output | 1 | Supervisor previous enable |
| mpp | output | 2 | Machine previous privilege |
| spp | output | 1 | Supervisor previous privilege |
| mepc | output | XLEN | Machine saved PC |
| sepc | output | XLEN | Supervisor saved PC |
| mtvec | output | XLEN | Machine trap vector |

## Verification
The bench aims at the tier boundary: a delegated line with a lower index than a pending machine line must lose, and a delegated line must never fire from machine level even with `mie` set; a flat priority encoder would take the wrong cause. It runs the vectored machine vector with both an interrupt and an exception, so a design that also offsets exceptions, or forgets to clear bit 0, lands on the wrong address. Debug mode is driven with a breakpoint, another code and a pending interrupt, catching a design that ignores the hart index, touches the saved PCs or lets interrupts through. Same-cycle interrupt and exception, and an interrupt away from a boundary, expose a wrong arbitration order.

// File: rtl/trap_entry_unit.sv
module trap_entry_unit #(
  parameter int XLEN = 32,
  parameter int NIRQ = 12,
  parameter int EXC_W = 4,
  parameter int HART_W = 4,
  parameter int BRK_CODE = 3,
  parameter logic [XLEN-1:0] DBG_BASE = 32'h0002_0000,
  parameter logic [XLEN-1:0] DBG_EXC = 32'h0002_1100,
  parameter logic [XLEN-1:0] RST_TVEC = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NIRQ-1:0]      irq_pend,
  input  logic [NIRQ-1:0]      irq_en,
  input  logic [NIRQ-1:0]      irq_dlg,
  input  logic [(1<<EXC_W)-1:0] exc_dlg,
  input  logic                 at_boundary,
  input  logic                 exc_req,
  input  logic [EXC_W-1:0]     exc_code,
  input  logic [XLEN-1:0]      pc_cur,
  input  logic                 dbg_active,
  input  logic [HART_W-1:0]    hart_id,
  input  logic                 vec_wr_m,
  input  logic                 vec_wr_s,
  input  logic [XLEN-1:0]      vec_wdata,
  input  logic                 ld_en,
  input  logic [1:0]           ld_priv,
  input  logic                 ld_mie,
  input  logic                 ld_sie,
  output logic                 trap_valid,
  output logic                 trap_to_s,
  output logic                 dbg_redirect,
  output logic [XLEN-1:0]      trap_pc,
  output logic [XLEN-1:0]      trap_cause,
  output logic [1:0]           priv,
  output logic                 mie,
  output logic                 sie,
  output logic                 mpie,
  output logic                 spie,
  output logic [1:0]           mpp,
  output logic                 spp,
  output logic [XLEN-1:0]      mepc,
  output logic [XLEN-1:0]      sepc,
  output logic [XLEN-1:0]      mtvec
);
  localparam int IDX_W = (NIRQ > 1) ? $clog2(NIRQ) : 1;
  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_S = 2'd1;
  localparam logic [1:0] PRV_M = 2'd3;

  logic [XLEN-1:0] stvec;
  logic [NIRQ-1:0] cand, m_set, s_set, sel;
  logic            m_ok, s_ok, take_irq, take_exc, take_dbg, dlg_hit, to_s;
  logic [IDX_W-1:0] idx;
  logic [XLEN-1:0] voff, hoff, m_pc, s_pc, dbg_pc, cause;

  assign cand  = irq_pend & irq_en;
  assign m_ok  = (priv != PRV_M) || mie;
  assign s_ok  = (priv == PRV_U) || ((priv == PRV_S) && sie);
  assign m_set = cand & ~irq_dlg & {NIRQ{m_ok}};
  assign s_set = cand & irq_dlg & {NIRQ{s_ok}};
  assign sel   = (|m_set) ? m_set : s_set;

  always_comb begin
    idx = '0;
    for (int i = NIRQ - 1; i >= 0; i--)
      if (sel[i]) idx = IDX_W'(i);
  end

  assign take_irq = at_boundary && !dbg_active && (|sel);
  assign take_exc = exc_req && !take_irq;
  assign take_dbg = take_exc && dbg_active;
  assign dlg_hit  = take_irq ? irq_dlg[idx] : exc_dlg[exc_code];
  assign to_s     = ((priv == PRV_U) || (priv == PRV_S)) && dlg_hit;

  assign voff   = {{(XLEN-IDX_W-2){1'b0}}, idx, 2'b00};
  assign hoff   = {{(XLEN-HART_W-2){1'b0}}, hart_id, 2'b00};
  assign m_pc   = {mtvec[XLEN-1:1], 1'b0} + ((mtvec[0] && take_irq) ? voff : '0);
  assign s_pc   = {stvec[XLEN-1:2], 2'b00};
  assign dbg_pc = (exc_code == EXC_W'(BRK_CODE)) ? DBG_BASE + hoff : DBG_EXC;
  assign cause  = take_irq ? {1'b1, {(XLEN-1-IDX_W){1'b0}}, idx}
                           : {{(XLEN-EXC_W){1'b0}}, exc_code};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_valid <= 1'b0; trap_to_s <= 1'b0; dbg_redirect <= 1'b0;
      trap_pc <= '0; trap_cause <= '0;
      priv <= PRV_M; mie <= 1'b0; sie <= 1'b0; mpie <= 1'b0; spie <= 1'b0;
      mpp <= PRV_U; spp <= 1'b0; mepc <= '0; sepc <= '0;
      mtvec <= RST_TVEC & ~XLEN'(2); stvec <= '0;
    end else begin
      trap_valid   <= take_irq || take_exc;
      trap_to_s    <= (take_irq || (take_exc && !dbg_active)) && to_s;
      dbg_redirect <= take_dbg;
      if (vec_wr_m) mtvec <= vec_wdata & ~XLEN'(2);
      if (vec_wr_s) stvec <= vec_wdata;
      if (take_dbg) begin
        trap_pc    <= dbg_pc;
        trap_cause <= cause;
      end else if (take_irq || take_exc) begin
        trap_cause <= cause;
        if (to_s) begin
          trap_pc <= s_pc;
          spie <= sie; spp <= priv[0]; sie <= 1'b0; priv <= PRV_S; sepc <= pc_cur;
        end else begin
          trap_pc <= m_pc;
          mpie <= mie; mpp <= priv; mie <= 1'b0; priv <= PRV_M; mepc <= pc_cur;
        end
      end else if (ld_en) begin
        priv <= ld_priv; mie <= ld_mie; sie <= ld_sie;
      end
    end
  end

  p_mentry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && !trap_to_s && !dbg_redirect) |->
      (priv == PRV_M && !mie && mpie == $past(mie) && mpp == $past(priv)));

  p_sentry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_to_s |-> (priv == PRV_S && !sie && spie == $past(sie) && spp == $past(priv[0])));

  p_sdest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_to_s |-> ($past(priv) != PRV_M && trap_valid));

  p_dbg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_redirect |-> ($stable(priv) && $stable(mepc) && $stable(sepc) && !trap_cause[XLEN-1]));

  p_m_irq_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && trap_cause[XLEN-1] && !trap_to_s) |->
      ($past(priv) != PRV_M || $past(mie)));

  p_vec_bit1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(vec_wr_m) |-> (mtvec[1] == 1'b0 && mtvec[0] == $past(vec_wdata[0])));
endmodule

// File: tb/trap_entry_unit_bench.sv
`timescale 1ns/1ps
module trap_entry_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] irq_pend = '0, irq_en = '0, irq_dlg = '0;
  logic [15:0] exc_dlg = '0;
  logic at_boundary = 1'b0, exc_req = 1'b0;
  logic [3:0] exc_code = '0;
  logic [31:0] pc_cur = '0;
  logic dbg_active = 1'b0;
  logic [3:0] hart_id = '0;
  logic vec_wr_m = 1'b0, vec_wr_s = 1'b0;
  logic [31:0] vec_wdata = '0;
  logic ld_en = 1'b0;
  logic [1:0] ld_priv = '0;
  logic ld_mie = 1'b0, ld_sie = 1'b0;
  logic trap_valid, trap_to_s, dbg_redirect;
  logic [31:0] trap_pc, trap_cause, mepc, sepc, mtvec;
  logic [1:0] priv, mpp;
  logic mie, sie, mpie, spie, spp;

  int total = 0;
  int bad = 0;
  logic [31:0] keep_m, keep_s;

  always #2 clk = ~clk;

  trap_entry_unit u_trap_entry_unit (
    .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .irq_en(irq_en), .irq_dlg(irq_dlg),
    .exc_dlg(exc_dlg), .at_boundary(at_boundary), .exc_req(exc_req), .exc_code(exc_code),
    .pc_cur(pc_cur), .dbg_active(dbg_active), .hart_id(hart_id), .vec_wr_m(vec_wr_m),
    .vec_wr_s(vec_wr_s), .vec_wdata(vec_wdata), .ld_en(ld_en), .ld_priv(ld_priv),
    .ld_mie(ld_mie), .ld_sie(ld_sie), .trap_valid(trap_valid), .trap_to_s(trap_to_s),
    .dbg_redirect(dbg_redirect), .trap_pc(trap_pc), .trap_cause(trap_cause), .priv(priv),
    .mie(mie), .sie(sie), .mpie(mpie), .spie(spie), .mpp(mpp), .spp(spp),
    .mepc(mepc), .sepc(sepc), .mtvec(mtvec));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic quiet();
    irq_pend = '0; irq_en = '0; irq_dlg = '0; exc_dlg = '0;
    at_boundary = 1'b0; exc_req = 1'b0; exc_code = '0; dbg_active = 1'b0;
  endtask

  task automatic load(input logic [1:0] p, input logic m, input logic s);
    ld_en = 1'b1; ld_priv = p; ld_mie = m; ld_sie = s;
    tick();
    ld_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 priv", {30'd0, priv}, 32'd3);
    chk("R11 enables", {27'd0, mie, sie, mpie, spie, spp}, 32'd0);
    chk("R11 strobe", {31'd0, trap_valid}, 32'd0);
    chk("R11 mepc", mepc, 32'd0);
    chk("R11 cause", trap_cause, 32'd0);
  endtask

  task automatic t_vectors();
    vec_wr_m = 1'b1; vec_wdata = 32'h0000_1007;
    tick();
    vec_wr_m = 1'b0;
    chk("R7 mtvec write", mtvec, 32'h0000_1005);
    vec_wr_s = 1'b1; vec_wdata = 32'h0000_2003;
    tick();
    vec_wr_s = 1'b0;
  endtask

  task automatic t_machine_irq();
    quiet();
    load(2'd3, 1'b0, 1'b0);
    irq_pend = 12'h020; irq_en = 12'h020; at_boundary = 1'b1; pc_cur = 32'h400;
    tick();
    chk("R2 masked at M", {31'd0, trap_valid}, 32'd0);
    load(2'd3, 1'b1, 1'b0);
    tick();
    chk("R2 taken", {31'd0, trap_valid}, 32'd1);
    chk("R4 cause", trap_cause, 32'h8000_0005);
    chk("R6 vectored pc", trap_pc, 32'h0000_1018);
    chk("R8 mie clear", {31'd0, mie}, 32'd0);
    chk("R8 mpie", {31'd0, mpie}, 32'd1);
    chk("R8 mpp", {30'd0, mpp}, 32'd3);
    chk("R8 mepc", mepc, 32'h400);
    quiet();
    tick();
    chk("R11 strobe one cycle", {31'd0, trap_valid}, 32'd0);
  endtask

  task automatic t_qualify();
    quiet();
    load(2'd3, 1'b1, 1'b0);
    irq_pend = 12'h020; irq_en = 12'h000; at_boundary = 1'b1;
    tick();
    chk("R1 pending not enabled", {31'd0, trap_valid}, 32'd0);
    irq_pend = 12'h000; irq_en = 12'h020;
    tick();
    chk("R1 enabled not pending", {31'd0, trap_valid}, 32'd0);
  endtask

  task automatic t_tiers();
    quiet();
    load(2'd0, 1'b0, 1'b0);
    irq_pend = 12'h088; irq_en = 12'hfff; irq_dlg = 12'h008; at_boundary = 1'b1; pc_cur = 32'h500;
    tick();
    chk("R3 machine tier first", trap_cause, 32'h8000_0007);
    chk("R6 vectored 7", trap_pc, 32'h0000_1020);
    chk("R8 mpp from user", {30'd0, mpp}, 32'd0);
    quiet();
    load(2'd0, 1'b0, 1'b0);
    irq_pend = 12'h210; irq_en = 12'hfff; at_boundary = 1'b1;
    tick();
    chk("R4 lowest index", trap_cause, 32'h8000_0004);
    quiet();
    load(2'd0, 1'b0, 1'b0);
    irq_pend = 12'h008; irq_en = 12'hfff; irq_dlg = 12'h008; at_boundary = 1'b1; pc_cur = 32'h600;
    tick();
    chk("R5 to supervisor", {31'd0, trap_to_s}, 32'd1);
    chk("R6 supervisor pc", trap_pc, 32'h0000_2000);
    chk("R8 sepc", sepc, 32'h600);
    chk("R8 spp from user", {31'd0, spp}, 32'd0);
    chk("R5 new priv", {30'd0, priv}, 32'd1);
    quiet();
    load(2'd1, 1'b0, 1'b0);
    irq_pend = 12'h008; irq_en = 12'hfff; irq_dlg = 12'h008; at_boundary = 1'b1;
    tick();
    chk("R3 S with sie clear", {31'd0, trap_valid}, 32'd0);
    quiet();
    load(2'd1, 1'b0, 1'b1);
    irq_pend = 12'h008; irq_en = 12'hfff; irq_dlg = 12'h008; at_boundary = 1'b1;
    tick();
    chk("R3 S with sie set", {31'd0, trap_to_s}, 32'd1);
    chk("R8 spie", {31'd0, spie}, 32'd1);
    chk("R8 sie clear", {31'd0, sie}, 32'd0);
    chk("R8 spp from S", {31'd0, spp}, 32'd1);
    quiet();
    load(2'd3, 1'b1, 1'b1);
    irq_pend = 12'h008; irq_en = 12'hfff; irq_dlg = 12'h008; at_boundary = 1'b1;
    tick();
    chk("R3 delegated never at M", {31'd0, trap_valid}, 32'd0);
  endtask

  task automatic t_exceptions();
    quiet();
    load(2'd3, 1'b1, 1'b0);
    exc_req = 1'b1; exc_code = 4'd2; exc_dlg = 16'h0004;
    tick();
    chk("R5 exception stays at M", {31'd0, trap_to_s}, 32'd0);
    chk("R4 exception cause", trap_cause, 32'd2);
    chk("R6 exception not vectored", trap_pc, 32'h0000_1004);
    quiet();
    load(2'd0, 1'b0, 1'b0);
    exc_req = 1'b1; exc_code = 4'd8; exc_dlg = 16'h0100;
    tick();
    chk("R5 delegated exception", {31'd0, trap_to_s}, 32'd1);
    chk("R4 cause 8", trap_cause, 32'd8);
    quiet();
    load(2'd0, 1'b0, 1'b0);
    exc_req = 1'b1; exc_code = 4'd8;
    tick();
    chk("R5 undelegated exception", {31'd0, trap_to_s}, 32'd0);
  endtask

  task automatic t_boundary();
    quiet();
    load(2'd0, 1'b0, 1'b0);
    irq_pend = 12'h004; irq_en = 12'h004;
    tick();
    chk("R10 no boundary no trap", {31'd0, trap_valid}, 32'd0);
    exc_req = 1'b1; exc_code = 4'd5;
    tick();
    chk("R10 exception off boundary", trap_cause, 32'd5);
    quiet();
    load(2'd0, 1'b0, 1'b0);
    irq_pend = 12'h004; irq_en = 12'h004; at_boundary = 1'b1; exc_req = 1'b1; exc_code = 4'd5;
    tick();
    chk("R10 interrupt wins", trap_cause, 32'h8000_0002);
  endtask

  task automatic t_debug();
    quiet();
    load(2'd0, 1'b1, 1'b1);
    keep_m = mepc; keep_s = sepc;
    dbg_active = 1'b1; hart_id = 4'd5; exc_req = 1'b1; exc_code = 4'd3;
    tick();
    chk("R9 redirect flag", {31'd0, dbg_redirect}, 32'd1);
    chk("R9 breakpoint entry", trap_pc, 32'h0002_0014);
    chk("R9 priv kept", {30'd0, priv}, 32'd0);
    chk("R9 mepc kept", mepc, keep_m);
    chk("R9 sepc kept", sepc, keep_s);
    exc_code = 4'd7;
    tick();
    chk("R9 other exception", trap_pc, 32'h0002_1100);
    exc_req = 1'b0; irq_pend = 12'h001; irq_en = 12'h001; at_boundary = 1'b1;
    tick();
    chk("R9 interrupts masked", {31'd0, trap_valid}, 32'd0);
    quiet();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_vectors();
    t_machine_irq();
    t_qualify();
    t_tiers();
    t_exceptions();
    t_boundary();
    t_debug();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule